// File: doc/BRIEF.md
# Sprite Line Compositor

This block draws sprites into a 256x256 frame buffer of 8-bit colour indices. A single start pulse starts a pass. The pass walks an object table of 64 eight-byte entries in sprite RAM, from the first entry to the last. Each entry describes a rectangle of 8 or 16 pixels per side. The rectangle is cut from a 256x256 texture page in byte-addressed graphics memory. The page sits behind a 16-bit base register, and the entry gives the texture start point inside the page.

A pass renders every enabled entry one pixel per cycle. A pixel can be mirrored on either axis. Screen and texture coordinates both wrap modulo 256. Texel value 0 is transparent and produces no write. Entries are drawn in table order, so a later entry covers an earlier one where they overlap. When the last pixel has been handled, the block raises a done flag and keeps it high until the next pass starts. Tilemaps, palette lookup and video timing belong to other blocks.

Top module: `sprite_compositor`

## Requirements
- R1: After reset `busy`, `done`, `gfx_req` and `fb_we` are 0. In the idle or done state, a `start` pulse starts a pass: `busy` is 1 and `done` is 0 from the next cycle. `done` stays 1 until the next start. A `start` during a pass is ignored, so each enabled opaque pixel is written exactly once per pass.
- R2: Entries are handled in ascending order, 0 to 63. Where two entries overlap, the value left in the frame buffer comes from the higher-numbered entry.
- R3: Entry n occupies sprite RAM bytes 8n to 8n+7. The fields are byte 0 attributes, byte 1 Y position, byte 2 X position, byte 4 texture X start and byte 5 texture Y start. Bytes 3, 6 and 7 have no effect on the output.
- R4: Attribute bit 7 enables an entry. A disabled entry issues no graphics read and makes no frame buffer write, whatever its other bytes hold.
- R5: Attribute bit 0 sets the width to 16 pixels (8 when clear). Attribute bit 1 sets the height to 16 pixels (8 when clear).
- R6: Attribute bit 2 mirrors horizontally and bit 3 mirrors vertically. On a mirrored axis, texel index i lands at destination offset size-1-i.
- R7: For texel (col,row), the graphics address is base*256 + ((texX+col) mod 256) + ((texY+row) mod 256)*256. The address is 24 bits wide, with `gfx_base` as base.
- R8: A texel of value 0 is not written. A nonzero texel is written unchanged as `fb_data`.
- R9: The destination pixel is X = (Xpos+offset) mod 256 and Y = (Ypos+offset) mod 256. It is written to `fb_addr` = Y*256 + X.
- R10: If entry 63 is enabled, `done` rises exactly GFX_LAT+1 cycles after the cycle of the final `gfx_req`. No frame buffer write happens while `done` is 1.
- R11: Sprite RAM read data returns one cycle after `oam_addr`. Graphics read data returns GFX_LAT cycles after a cycle with `gfx_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts a pass |
| gfx_base | input | 16 | Texture page base, in units of 256 bytes |
| oam_addr | output | 9 | Sprite RAM byte address |
| oam_data | input | 8 | Sprite RAM read data, one cycle after the address |
| gfx_req | output | 1 | Graphics memory read strobe |
| gfx_addr | output | 24 | Graphics memory byte address |
| gfx_data | input | 8 | Graphics read data, GFX_LAT cycles after the strobe |
| fb_we | output | 1 | Frame buffer write enable |
| fb_addr | output | 16 | Frame buffer address, Y*256+X |
| fb_data | output | 8 | Frame buffer write data |
| busy | output | 1 | A pass is running |
| done | output | 1 | The last pass has finished |

## Verification
Each graphics request has its write decision due exactly GFX_LAT cycles later, in the cycle its texel returns. The bench models both memories with those fixed latencies and records writes at the falling edge, when the whole cycle is settled. `busy` is checked on the first falling edge after the start pulse. The arrival of `done` is measured in cycles from the last observed `gfx_req` and must equal GFX_LAT+1. The frame buffer contents and the write count are compared only once `done` has risen, against a model that replays the table arithmetically in entry order.

// File: rtl/sprc_pkg.sv
package sprc_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int BYTE_W      = $clog2(ENTRY_BYTES);
    localparam int GFX_AW      = 24;
    localparam int FB_AW       = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAW,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic       wide;
        logic       tall;
        logic       flip_h;
        logic       flip_v;
        logic [7:0] ypos;
        logic [7:0] xpos;
        logic [7:0] tex_x;
        logic [7:0] tex_y;
    } sprite_t;

    // Highest pixel index along one axis for the selected size.
    function automatic logic [3:0] span_last(input logic big);
        return big ? 4'd15 : 4'd7;
    endfunction

    // Screen offset of texel index i along one axis.
    function automatic logic [7:0] place_off(input logic flip, input logic big,
                                             input logic [3:0] i);
        logic [3:0] v;
        v = flip ? (span_last(big) - i) : i;
        return {4'h0, v};
    endfunction

endpackage

// File: rtl/sprite_seq.sv
module sprite_seq
    import sprc_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int ENT_W  = $clog2(ENTRIES),
    localparam int OAM_AW = ENT_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tail_only,
    input  logic [7:0]        oam_data,
    output logic [OAM_AW-1:0] oam_addr,
    output sprite_t           spr,
    output logic [3:0]        col,
    output logic [3:0]        row,
    output logic              drawing,
    output logic              busy,
    output logic              done
);

    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(ENTRIES - 1);

    seq_state_e        st;
    logic [ENT_W-1:0]  ent;
    logic [BYTE_W-1:0] fcnt;

    assign oam_addr = {ent, fcnt};
    assign drawing  = (st == ST_DRAW);
    assign busy     = (st == ST_FETCH) || (st == ST_DRAW) || (st == ST_DRAIN);
    assign done     = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ent  <= '0;
            fcnt <= '0;
            col  <= '0;
            row  <= '0;
            spr  <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        st   <= ST_FETCH;
                        ent  <= '0;
                        fcnt <= '0;
                    end
                end
                ST_FETCH: begin
                    fcnt <= fcnt + 1'b1;
                    // data of byte k arrives while fcnt == k+1
                    case (fcnt)
                        3'd1: begin
                            spr.en     <= oam_data[7];
                            spr.wide   <= oam_data[0];
                            spr.tall   <= oam_data[1];
                            spr.flip_h <= oam_data[2];
                            spr.flip_v <= oam_data[3];
                        end
                        3'd2: spr.ypos  <= oam_data;
                        3'd3: spr.xpos  <= oam_data;
                        3'd5: spr.tex_x <= oam_data;
                        3'd6: spr.tex_y <= oam_data;
                        default: ;
                    endcase
                    if (fcnt == 3'd6) begin
                        fcnt <= '0;
                        if (spr.en) begin
                            st  <= ST_DRAW;
                            col <= '0;
                            row <= '0;
                        end else if (ent == LAST_ENT) begin
                            st <= ST_DRAIN;
                        end else begin
                            ent <= ent + 1'b1;
                        end
                    end
                end
                ST_DRAW: begin
                    if (col == span_last(spr.wide)) begin
                        col <= '0;
                        if (row == span_last(spr.tall)) begin
                            row <= '0;
                            if (ent == LAST_ENT) begin
                                st <= ST_DRAIN;
                            end else begin
                                st  <= ST_FETCH;
                                ent <= ent + 1'b1;
                            end
                        end else begin
                            row <= row + 1'b1;
                        end
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (tail_only) st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/texel_addr.sv
module texel_addr
    import sprc_pkg::*;
(
    input  sprite_t           spr,
    input  logic [3:0]        col,
    input  logic [3:0]        row,
    input  logic [15:0]       base,
    output logic [GFX_AW-1:0] gfx_addr,
    output logic [FB_AW-1:0]  fb_addr
);

    logic [7:0] tcol, trow, dx, dy;

    always_comb begin
        tcol     = spr.tex_x + {4'h0, col};
        trow     = spr.tex_y + {4'h0, row};
        gfx_addr = {base, 8'h00} + {8'h00, trow, tcol};
        dx       = spr.xpos + place_off(spr.flip_h, spr.wide, col);
        dy       = spr.ypos + place_off(spr.flip_v, spr.tall, row);
        fb_addr  = {dy, dx};
    end

endmodule

// File: rtl/gfx_pipe.sv
module gfx_pipe
    import sprc_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [FB_AW-1:0] in_addr,
    output logic             out_valid,
    output logic [FB_AW-1:0] out_addr,
    output logic             tail_only
);

    logic [LAT-1:0]   vld;
    logic [FB_AW-1:0] adr [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld[0] <= in_valid;
            for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
        end
    end

    always_ff @(posedge clk) begin
        adr[0] <= in_addr;
        for (int i = 1; i < LAT; i++) adr[i] <= adr[i-1];
    end

    assign out_valid = vld[LAT-1];
    assign out_addr  = adr[LAT-1];

    generate
        if (LAT == 1) begin : g_one
            assign tail_only = 1'b1;
        end else begin : g_many
            assign tail_only = ~|vld[LAT-2:0];
        end
    endgenerate

endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
    import sprc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int GFX_LAT = 2,
    localparam int OAM_AW = $clog2(ENTRIES) + BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       gfx_base,
    output logic [OAM_AW-1:0] oam_addr,
    input  logic [7:0]        oam_data,
    output logic              gfx_req,
    output logic [GFX_AW-1:0] gfx_addr,
    input  logic [7:0]        gfx_data,
    output logic              fb_we,
    output logic [FB_AW-1:0]  fb_addr,
    output logic [7:0]        fb_data,
    output logic              busy,
    output logic              done
);

    sprite_t          spr;
    logic [3:0]       col, row;
    logic             drawing, tail_only, ret_valid;
    logic [FB_AW-1:0] dst_addr;

    sprite_seq #(.ENTRIES(ENTRIES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .tail_only(tail_only),
        .oam_data(oam_data), .oam_addr(oam_addr), .spr(spr),
        .col(col), .row(row), .drawing(drawing), .busy(busy), .done(done)
    );

    texel_addr u_addr (
        .spr(spr), .col(col), .row(row), .base(gfx_base),
        .gfx_addr(gfx_addr), .fb_addr(dst_addr)
    );

    gfx_pipe #(.LAT(GFX_LAT)) u_pipe (
        .clk(clk), .rst(rst), .in_valid(drawing), .in_addr(dst_addr),
        .out_valid(ret_valid), .out_addr(fb_addr), .tail_only(tail_only)
    );

    assign gfx_req = drawing;
    assign fb_we   = ret_valid && (gfx_data != 8'h00);
    assign fb_data = gfx_data;

endmodule

// File: rtl/sprite_compositor_chk.sv
module sprite_compositor_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       gfx_req,
    input logic       fb_we,
    input logic [7:0] fb_data
);

    // R8: a transparent texel never reaches the frame buffer
    a_r8_no_clear_write: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_data != 8'h00));

    // R1: busy and done are never both high
    a_r1_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4: graphics reads only happen inside a pass
    a_r4_req_in_pass: assert property (@(posedge clk) disable iff (rst)
        gfx_req |-> busy);

    // R10: no write while done is high
    a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !fb_we);

    // R10: done only follows a running pass
    a_r10_done_after_pass: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

endmodule

bind sprite_compositor sprite_compositor_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .gfx_req(gfx_req), .fb_we(fb_we), .fb_data(fb_data)
);

// File: tb/sprite_compositor_tb.sv
module sprite_compositor_tb;

    localparam int LAT = 2;

    logic        clk = 0, rst = 1, start = 0;
    logic [15:0] gfx_base = 0;
    logic [8:0]  oam_addr;
    logic [7:0]  oam_data;
    logic        gfx_req;
    logic [23:0] gfx_addr;
    logic [7:0]  gfx_data;
    logic        fb_we;
    logic [15:0] fb_addr;
    logic [7:0]  fb_data;
    logic        busy, done;

    always #10 clk = ~clk;

    sprite_compositor #(.ENTRIES(64), .GFX_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .gfx_base(gfx_base),
        .oam_addr(oam_addr), .oam_data(oam_data), .gfx_req(gfx_req),
        .gfx_addr(gfx_addr), .gfx_data(gfx_data), .fb_we(fb_we),
        .fb_addr(fb_addr), .fb_data(fb_data), .busy(busy), .done(done)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [7:0] oam [512];
    logic [7:0] gd  [LAT];
    logic [7:0] dutfb [int];
    logic [7:0] expfb [int];
    int wr_cnt, exp_cnt, req_cnt, cyc, last_req, done_cyc;
    logic prev_done;

    function automatic logic [7:0] tex(input logic [23:0] a);
        logic [7:0] t;
        if (a[2:0] == 3'b000) return 8'h00;
        t = a[7:0] ^ (a[15:8] * 8'd5) ^ a[23:16];
        return (t == 8'h00) ? 8'h5A : t;
    endfunction

    // R11: sprite RAM answers in one cycle, graphics memory in LAT cycles
    always @(posedge clk) begin
        oam_data <= oam[oam_addr];
        gd[0] <= tex(gfx_addr);
        for (int i = 1; i < LAT; i++) gd[i] <= gd[i-1];
    end
    assign gfx_data = gd[LAT-1];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && fb_we) begin
            dutfb[int'(fb_addr)] = fb_data;
            wr_cnt++;
        end
        if (!rst && gfx_req) begin
            last_req = cyc;
            req_cnt++;
        end
        if (done && !prev_done) done_cyc = cyc;
        prev_done <= done;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input logic [15:0] base);
        expfb.delete();
        exp_cnt = 0;
        for (int e = 0; e < 64; e++) begin
            logic [7:0] at, y, x, tx, ty;
            int w, h;
            at = oam[e*8]; y = oam[e*8+1]; x = oam[e*8+2];
            tx = oam[e*8+4]; ty = oam[e*8+5];
            if (!at[7]) continue;
            w = at[0] ? 16 : 8;
            h = at[1] ? 16 : 8;
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    logic [23:0] a;
                    logic [7:0] p, dx, dy;
                    a = {base, 8'h00} + {8'h00, 8'(ty + r), 8'(tx + c)};
                    p = tex(a);
                    if (p == 0) continue;
                    dx = x + 8'(at[2] ? (w - 1 - c) : c);
                    dy = y + 8'(at[3] ? (h - 1 - r) : r);
                    expfb[int'({dy, dx})] = p;
                    exp_cnt++;
                end
            end
        end
    endtask

    task automatic clear_oam();
        for (int i = 0; i < 512; i++) oam[i] = 8'h00;
    endtask

    task automatic put(input int e, input logic [7:0] at, input logic [7:0] y,
                       input logic [7:0] x, input logic [7:0] tx, input logic [7:0] ty);
        oam[e*8] = at; oam[e*8+1] = y; oam[e*8+2] = x;
        oam[e*8+4] = tx; oam[e*8+5] = ty;
    endtask

    task automatic run(input string tag, input logic [15:0] base,
                       input bit timing, input bit restart_mid);
        int guard;
        gfx_base = base;
        model(base);
        dutfb.delete();
        wr_cnt = 0; req_cnt = 0; done_cyc = -1; last_req = -1;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        // R1: pass running from the cycle after start
        check(busy === 1'b1 && done === 1'b0, "R1 busy after start", busy, 1);
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (restart_mid && guard == 150) start = 1;
            if (restart_mid && guard == 151) start = 0;
        end
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, {"R1 done held ", tag}, done, 1);
        // R2 R8: total writes equal the opaque pixel count
        check(wr_cnt == exp_cnt, {"R2 R8 write count ", tag}, wr_cnt, exp_cnt);
        check(dutfb.num() == expfb.num(), {"R9 touched pixels ", tag},
              dutfb.num(), expfb.num());
        foreach (expfb[k]) begin
            int act;
            act = dutfb.exists(k) ? int'(dutfb[k]) : -1;
            check(act == int'(expfb[k]), {"R2 R3 R5 R6 R7 R9 pixel ", tag}, act, expfb[k]);
        end
        if (timing)
            check(done_cyc - last_req == LAT + 1, {"R10 done latency ", tag},
                  done_cyc - last_req, LAT + 1);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc = 0; prev_done = 0; wr_cnt = 0; req_cnt = 0;
        for (int i = 0; i < LAT; i++) gd[i] = 8'h00;
        clear_oam();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !gfx_req && !fb_we, "R1 reset state",
              {busy, done, gfx_req, fb_we}, 0);

        // R4: disabled entries with every other bit set make no reads or writes
        for (int e = 0; e < 64; e++) begin
            put(e, 8'h7F, 8'(e), 8'(e * 3), 8'hFF, 8'h11);
            oam[e*8+3] = 8'hFF;
        end
        run("disabled", 16'h0042, 0, 0);
        check(req_cnt == 0, "R4 no graphics reads", req_cnt, 0);
        check(wr_cnt == 0, "R4 no writes", wr_cnt, 0);

        // R7 R8 R9: one plain 8x8 sprite
        clear_oam();
        put(0, 8'h80, 8'd20, 8'd10, 8'd3, 8'd7);
        run("plain", 16'h0000, 0, 0);

        // R5 R6 R9 R7: sizes, mirroring, screen and texture wrap
        clear_oam();
        put(5,  8'h85, 8'd40,  8'd60,  8'd17,  8'd90);
        put(9,  8'h8A, 8'd252, 8'd250, 8'd33,  8'd5);
        put(12, 8'h8F, 8'd250, 8'd3,   8'd248, 8'd250);
        put(20, 8'h83, 8'd100, 8'd100, 8'd0,   8'd0);
        put(63, 8'h84, 8'd7,   8'd254, 8'd1,   8'd2);
        run("sizes mirror wrap", 16'h1234, 1, 0);

        // R2 R3 R10 R1: dense overlapping table, junk in unused bytes, start mid-pass
        clear_oam();
        for (int e = 0; e < 64; e++) begin
            logic [7:0] at;
            at = 8'($urandom);
            if (e % 3 == 0 || e == 63) at[7] = 1'b1;
            put(e, at, 8'(100 + $urandom_range(0, 20)), 8'(100 + $urandom_range(0, 20)),
                8'($urandom), 8'($urandom));
            oam[e*8+3] = 8'($urandom);
            oam[e*8+6] = 8'($urandom);
            oam[e*8+7] = 8'($urandom);
        end
        run("overlap restart", 16'hBEEF, 1, 1);

        // R1: a new pass from the done state with another base
        run("second pass", 16'h00C3, 1, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule